// File: doc/BRIEF.md
# Multiphase-Select Digital Frequency Synthesizer

The block builds an output clock without any counter running at the output rate. A bank of equal-frequency square waves, each shifted from its neighbour by one fixed tap spacing, feeds two selection multiplexers. One multiplexer picks the tap whose next rising edge starts the following output period. The other picks the tap whose rising edge ends the high phase. Both selections are kept in Gray code and decoded at the multiplexer. They are advanced by modulo-N arithmetic, where N is the number of taps.

The rise select steps by the frequency word on every output period, so the output period equals that word times the tap spacing. At the same edge the fall select is set to the current rise position plus the duty word, modulo N, so the high time equals the duty word times the tap spacing. Both words are sampled only at the rising edge that opens a period. A pair that is out of range is refused, and the last accepted pair stays in force.

Top module: `dfs_multiphase_synth`

## Requirements
- R1: While `rstN` is low, `clkOut` is low.
- R2: After reset both selects start at tap 0, so the first rising edge of `clkOut` coincides with a rising edge of tap 0.
- R3: Each output period lasts F tap spacings, and each rising edge of `clkOut` lands on tap index (previous index + F) mod N, where F is the accepted frequency word.
- R4: The high time of `clkOut` lasts D tap spacings, where D is the accepted duty word.
- R5: A frequency word is accepted only when 2 <= F <= N/2; otherwise the previously accepted pair (F and D) stays in force. The reset pair is F = 8, D = 4.
- R6: A duty word is accepted only when 1 <= D < F, with F the incoming frequency word; otherwise the previously accepted pair stays in force.
- R7: The words are sampled only at the rising edge of `clkOut`. A change made inside a period alters neither that period's high time nor its length, and takes effect from the next period.
- R8: Tap selects are stored in Gray code. Each multiplexer passes the tap whose index equals the binary value of its select, so each period shows exactly one rising edge and one falling edge at the times given by R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tapsIn | input | 16 | Phase taps; tap i rises i tap spacings after tap 0, all at 50 % duty |
| rstN | input | 1 | Asynchronous active-low reset |
| fcwIn | input | 4 | Frequency word: output period in tap spacings |
| dcwIn | input | 4 | Duty word: high time in tap spacings |
| clkOut | output | 1 | Synthesized clock |

## Verification
The assertions assume ideal taps: 50 % duty, no skew, rising in index order, and only one tap rising at any instant. Under that assumption a newly selected tap is always low when the multiplexer switches to it, so every rising edge of the rise path finds the output low and every fall-path edge after the first period finds it high. The bench models the taps from a single modular position counter, so the spacing is exact and the skew is zero. Random pairs are drawn only from the legal range. Out-of-range words are applied only in directed steps, where the expected result is the pair held from before.

// File: rtl/dfs_pkg.sv
`timescale 1ns/1ps
package dfs_pkg;
  localparam int TAPS  = 16;
  localparam int SEL_W = $clog2(TAPS);
  localparam logic [SEL_W:0] TAPS_WIDE = (SEL_W+1)'(TAPS);

  typedef logic [SEL_W-1:0] sel_t;

  // strobes handed from control to datapath at each period start
  typedef struct packed {
    sel_t riseStep;
    sel_t fallOffset;
  } step_t;

  function automatic sel_t bin2gray(input sel_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic sel_t gray2bin(input sel_t g);
    sel_t b;
    b[SEL_W-1] = g[SEL_W-1];
    for (int i = SEL_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic sel_t modAdd(input sel_t a, input sel_t c);
    logic [SEL_W:0] s;
    s = {1'b0, a} + {1'b0, c};
    if (s >= TAPS_WIDE) s = s - TAPS_WIDE;
    return s[SEL_W-1:0];
  endfunction
endpackage

// File: rtl/dfs_tap_mux.sv
`timescale 1ns/1ps
module dfs_tap_mux
  import dfs_pkg::*;
(
  input  logic [TAPS-1:0] taps,
  input  sel_t            selGray,
  output logic            tapOut
);
  sel_t selBin;
  logic [TAPS-1:0] hit;

  assign selBin = gray2bin(selGray);

  for (genvar i = 0; i < TAPS; i++) begin : gTap
    assign hit[i] = taps[i] & (selBin == sel_t'(i));
  end

  assign tapOut = |hit;
endmodule

// File: rtl/dfs_ctrl.sv
`timescale 1ns/1ps
module dfs_ctrl
  import dfs_pkg::*;
#(
  parameter int RST_FCW  = 8,
  parameter int RST_DUTY = 4
) (
  input  logic  riseClk,
  input  logic  rstN,
  input  sel_t  fcwIn,
  input  sel_t  dcwIn,
  output step_t step
);
  localparam sel_t MIN_F = sel_t'(2);
  localparam sel_t MAX_F = sel_t'(TAPS / 2);
  localparam sel_t MIN_D = sel_t'(1);

  sel_t heldF;
  sel_t heldD;
  logic freqOk;
  logic dutyOk;
  logic pairOk;

  assign freqOk = (fcwIn >= MIN_F) && (fcwIn <= MAX_F);
  assign dutyOk = (dcwIn >= MIN_D) && (dcwIn < fcwIn);
  assign pairOk = freqOk && dutyOk;

  always_comb begin
    step.riseStep   = pairOk ? fcwIn : heldF;
    step.fallOffset = pairOk ? dcwIn : heldD;
  end

  always_ff @(posedge riseClk or negedge rstN) begin
    if (!rstN) begin
      heldF <= sel_t'(RST_FCW);
      heldD <= sel_t'(RST_DUTY);
    end else begin
      heldF <= step.riseStep;
      heldD <= step.fallOffset;
    end
  end

  // R5: the step used for the period is always within the legal span
  a_r5_step_legal: assert property (@(posedge riseClk) disable iff (!rstN)
    (step.riseStep >= MIN_F) && (step.riseStep <= MAX_F));

  // R6: the fall offset always lies strictly inside the period
  a_r6_duty_inside: assert property (@(posedge riseClk) disable iff (!rstN)
    (step.fallOffset >= MIN_D) && (step.fallOffset < step.riseStep));
endmodule

// File: rtl/dfs_datapath.sv
`timescale 1ns/1ps
module dfs_datapath
  import dfs_pkg::*;
(
  input  logic [TAPS-1:0] taps,
  input  logic            rstN,
  input  step_t           step,
  output logic            riseClk,
  output logic            clkOut
);
  sel_t riseGray;
  sel_t fallGray;
  sel_t riseBin;
  logic fallClk;
  logic riseTog;
  logic fallTog;
  logic started;

  dfs_tap_mux uRiseMux (.taps(taps), .selGray(riseGray), .tapOut(riseClk));
  dfs_tap_mux uFallMux (.taps(taps), .selGray(fallGray), .tapOut(fallClk));

  assign riseBin = gray2bin(riseGray);

  // period start: advance the rise tap, place the fall tap
  always_ff @(posedge riseClk or negedge rstN) begin
    if (!rstN) begin
      riseGray <= '0;
      fallGray <= '0;
      riseTog  <= 1'b0;
      started  <= 1'b0;
    end else begin
      riseGray <= bin2gray(modAdd(riseBin, step.riseStep));
      fallGray <= bin2gray(modAdd(riseBin, step.fallOffset));
      riseTog  <= ~riseTog;
      started  <= 1'b1;
    end
  end

  // the fall path acts only while the output is high
  always_ff @(posedge fallClk or negedge rstN) begin
    if (!rstN) fallTog <= 1'b0;
    else if (riseTog != fallTog) fallTog <= ~fallTog;
  end

  assign clkOut = riseTog ^ fallTog;

  // R3: a new period only starts from a low output
  a_r3_rise_from_low: assert property (@(posedge riseClk) disable iff (!rstN)
    riseTog == fallTog);

  // R4: once running, every fall-tap edge finds the output high
  a_r4_fall_from_high: assert property (@(posedge fallClk) disable iff (!rstN)
    started |-> (riseTog != fallTog));
endmodule

// File: rtl/dfs_multiphase_synth.sv
`timescale 1ns/1ps
module dfs_multiphase_synth
  import dfs_pkg::*;
#(
  parameter int RST_FCW  = 8,
  parameter int RST_DUTY = 4
) (
  input  logic [TAPS-1:0]  tapsIn,
  input  logic             rstN,
  input  logic [SEL_W-1:0] fcwIn,
  input  logic [SEL_W-1:0] dcwIn,
  output logic             clkOut
);
  step_t step;
  logic  riseClk;

  dfs_ctrl #(.RST_FCW(RST_FCW), .RST_DUTY(RST_DUTY)) uCtrl (
    .riseClk(riseClk), .rstN(rstN), .fcwIn(fcwIn), .dcwIn(dcwIn), .step(step)
  );

  dfs_datapath uPath (
    .taps(tapsIn), .rstN(rstN), .step(step), .riseClk(riseClk), .clkOut(clkOut)
  );
endmodule

// File: tb/tb_dfs_multiphase_synth.sv
`timescale 1ns/1ps
module tb_dfs_multiphase_synth;
  localparam int  K = 16;
  localparam real DELTA = 2.0;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [K-1:0] tapsIn;
  logic [3:0] fcwIn = 4'd8;
  logic [3:0] dcwIn = 4'd4;
  logic       clkOut;
  int         pos = 0;
  int         errors = 0;
  int         checks = 0;
  int         curF = 8;
  int         curD = 4;

  dfs_multiphase_synth dut (
    .tapsIn(tapsIn), .rstN(rstN), .fcwIn(fcwIn), .dcwIn(dcwIn), .clkOut(clkOut)
  );

  always #10 clk = ~clk;

  function automatic logic [K-1:0] tapsAt(input int p);
    logic [K-1:0] v;
    for (int i = 0; i < K; i++) v[i] = (((p - i + K) % K) < K / 2);
    return v;
  endfunction

  function automatic bit pairLegal(input int f, input int d);
    return (f >= 2) && (f <= K / 2) && (d >= 1) && (d < f);
  endfunction

  initial begin
    tapsIn = tapsAt(0);
    #1;
    forever begin
      pos = (pos + 1) % K;
      tapsIn = tapsAt(pos);
      #(DELTA);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // one full period from the next rising edge
  task automatic measure(input int expF, input int expD, input string req);
    realtime t0, t1, t2;
    int p0, p2, per, hi;
    @(posedge clkOut); t0 = $realtime; p0 = pos;
    @(negedge clkOut); t1 = $realtime;
    @(posedge clkOut); t2 = $realtime; p2 = pos;
    per = int'((t2 - t0) / DELTA);
    hi  = int'((t1 - t0) / DELTA);
    check(per == expF, req, "R3 period taps", per, expF);
    check(hi == expD, req, "R4 high taps", hi, expD);
    check(((p2 - p0 + K) % K) == expF, req, "R8 rise tap step", (p2 - p0 + K) % K, expF);
  endtask

  task automatic applyPair(input int f, input int d, input string req);
    @(posedge clkOut);
    #(DELTA / 2.0);
    fcwIn = 4'(f);
    dcwIn = 4'(d);
    if (pairLegal(f, d)) begin
      curF = f;
      curD = d;
    end
    measure(curF, curD, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    realtime t0, t1, t2;
    int p, f, d;
    void'($urandom(24680));
    // R1: low under reset while taps run
    repeat (2) @(negedge clk);
    check(clkOut == 1'b0, "R1", "low in reset", clkOut, 0);
    repeat (3) @(negedge clk);
    check(clkOut == 1'b0, "R1", "low in reset later", clkOut, 0);
    rstN = 1'b1;
    // R2: first rise on tap 0
    @(posedge clkOut);
    p = pos;
    check(p == 0, "R2", "first rise tap", p, 0);
    measure(8, 4, "R5 reset pair");

    // directed legal corners
    applyPair(2, 1, "R3 min period");
    applyPair(8, 7, "R4 max duty");
    applyPair(8, 1, "R4 min duty");
    applyPair(3, 2, "R3 odd period");
    applyPair(5, 2, "R3 five");

    // R5: illegal frequency words hold the pair
    applyPair(0, 0, "R5 word zero");
    applyPair(1, 0, "R5 word one");
    applyPair(9, 3, "R5 above half");
    applyPair(15, 4, "R5 far above");
    // R6: illegal duty words hold the pair
    applyPair(6, 0, "R6 duty zero");
    applyPair(6, 6, "R6 duty equal");
    applyPair(4, 7, "R6 duty above");

    // R7: change inside a period
    applyPair(5, 2, "R7 setup");
    @(posedge clkOut); t0 = $realtime;
    #(DELTA / 2.0);
    fcwIn = 4'd7; dcwIn = 4'd3;
    @(negedge clkOut); t1 = $realtime;
    @(posedge clkOut); t2 = $realtime;
    check(int'((t1 - t0) / DELTA) == 2, "R7", "old high kept", int'((t1 - t0) / DELTA), 2);
    check(int'((t2 - t0) / DELTA) == 5, "R7", "old period kept", int'((t2 - t0) / DELTA), 5);
    @(negedge clkOut); t1 = $realtime;
    @(posedge clkOut); t0 = $realtime;
    check(int'((t1 - t2) / DELTA) == 3, "R7", "new high", int'((t1 - t2) / DELTA), 3);
    check(int'((t0 - t2) / DELTA) == 7, "R7", "new period", int'((t0 - t2) / DELTA), 7);
    curF = 7; curD = 3;

    // random legal pairs
    for (int n = 0; n < 24; n++) begin
      f = int'($urandom_range(K / 2, 2));
      d = int'($urandom_range(f - 1, 1));
      applyPair(f, d, "R3 R4 random");
    end
    finishRun();
  end
endmodule